// File: doc/BRIEF.md
# Memory-Mapped Configuration Address Translator

This block sits between a CPU-side request port and the configuration request port of a single PCI root bus. Any CPU access whose address falls inside a 4 MiB window based at 0x8080_0000 becomes one configuration request. The translated address keeps the low register offset as it is. The device/function field is the position of the lowest set bit among the eleven select lines above the offset. When no select line is set, the field takes the value one past the last select position.

Writes go out as a single-cycle configuration request and are acknowledged in that same cycle. A read holds the block busy until the bus side returns data. The block then raises a one-cycle response that carries the returned data, with the lanes above the access size cleared. Data is little-endian in both directions: a 1-byte access uses byte lane 0 and a 2-byte access uses lanes 0 and 1. Accesses outside the window and accesses with an unsupported size produce no activity at all.

Top module: `cfgx_xlate`

## Requirements
- R1: A request is accepted only when req_valid and req_ready are both high and req_addr[31:22] equals 10'h202, which is the window 0x8080_0000 to 0x80BF_FFFF. Any other address produces no cfg_req_valid and no resp_valid, and req_ready stays high.
- R2: cfg_addr[10:0] equals req_addr[10:0] of the accepted request.
- R3: cfg_addr[14:11] is i, the index of the lowest set bit of req_addr[21:11], where index 0 is bit 11 and index 10 is bit 21. Higher set bits have no effect.
- R4: When req_addr[21:11] is all zero, cfg_addr[14:11] is 11 (4'b1011).
- R5: req_size is a byte count. Only the values 1, 2 and 4 are accepted, and cfg_size carries that value unchanged. Any other size is ignored in the same way as in R1.
- R6: cfg_wr copies req_wr. cfg_wdata holds req_wdata in little-endian lanes, with the bytes at and above the size cleared: size 1 keeps [7:0] and size 2 keeps [15:0].
- R7: cfg_req_valid is high for exactly the one cycle after the clock edge that accepts a request. For a write, resp_valid is high in that same cycle with resp_rdata equal to 0.
- R8: After a read is accepted, req_ready is low from the next cycle on. The first clock edge that samples cfg_rvalid high, which may be the one ending the cfg_req_valid cycle, is followed by one cycle with resp_valid high, resp_rdata equal to cfg_rdata masked to the read size as in R6, and req_ready high again.
- R9: A request presented while req_ready is low is ignored and yields no cfg_req_valid. A cfg_rvalid pulse while no read is outstanding yields no resp_valid.
- R10: While and right after reset (rst high, synchronous), cfg_req_valid and resp_valid are low and req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | CPU request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | 32 | CPU byte address |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_size | input | 3 | Access size in bytes (1, 2 or 4) |
| req_wdata | input | 32 | Write data, little-endian lanes |
| resp_valid | output | 1 | One-cycle completion strobe |
| resp_rdata | output | 32 | Read data for the completion (0 for writes) |
| cfg_req_valid | output | 1 | One-cycle configuration request strobe |
| cfg_wr | output | 1 | Configuration request direction |
| cfg_addr | output | 15 | Configuration address: device/function field over register offset |
| cfg_size | output | 3 | Configuration access size in bytes |
| cfg_wdata | output | 32 | Configuration write data, lane-masked |
| cfg_rvalid | input | 1 | Configuration read data valid |
| cfg_rdata | input | 32 | Configuration read data |

## Verification
The hardest case to reach from the ports is a read whose data returns with zero latency. In that case cfg_rvalid is already high during the same cycle that cfg_req_valid appears, and a new CPU request is knocking while the read is outstanding. The stimulus places the read-data pulse at latencies of zero, one and two cycles across the sweep of all twelve select positions. It also holds a write on the request port throughout one read's wait. A separate stray data pulse with no read outstanding is added to show that it is discarded.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

   // Controller state: idle, or waiting for configuration read data.
   typedef enum logic [0:0] {
      ST_IDLE = 1'b0,
      ST_WAIT = 1'b1
   } cfgx_state_e;

   // Number of bits needed for a byte count up to nlane inclusive.
   function automatic int size_width(input int nlane);
      return $clog2(nlane) + 1;
   endfunction

endpackage

// File: rtl/cfgx_win_decode.sv
module cfgx_win_decode #(
   parameter int              AW       = 32,
   parameter int              WIN_BITS = 22,
   parameter logic [AW-1:0]   WIN_BASE = 32'h8080_0000
) (
   input  logic [AW-WIN_BITS-1:0] addr_hi,
   output logic                   hit
);

   localparam int HI_W = AW - WIN_BITS;
   localparam logic [HI_W-1:0] BASE_HI = WIN_BASE[AW-1:WIN_BITS];

   generate
      if (WIN_BITS >= AW) begin : g_bad_win
         $error("cfgx_win_decode: window must be smaller than the address space");
      end
      if (WIN_BASE[WIN_BITS-1:0] != '0) begin : g_bad_align
         $error("cfgx_win_decode: window base must be aligned to the window size");
      end
   endgenerate

   always_comb begin
      hit = (addr_hi == BASE_HI);
   end

endmodule

// File: rtl/cfgx_sel_scan.sv
module cfgx_sel_scan #(
   parameter int SEL_BITS = 11,
   localparam int IDX_W   = $clog2(SEL_BITS + 1)
) (
   input  logic [SEL_BITS-1:0] sel,
   output logic [IDX_W-1:0]    idx
);

   // seen[k] is high when any select bit below position k is set.
   logic [SEL_BITS:0]   seen;
   logic [SEL_BITS-1:0] first;

   generate
      if (SEL_BITS < 1) begin : g_bad_sel
         $error("cfgx_sel_scan: at least one select bit is required");
      end
   endgenerate

   assign seen[0] = 1'b0;

   generate
      for (genvar k = 0; k < SEL_BITS; k++) begin : g_chain
         assign seen[k+1] = seen[k] | sel[k];
         assign first[k]  = sel[k] & ~seen[k];
      end
   endgenerate

   always_comb begin
      idx = '0;
      for (int k = 0; k < SEL_BITS; k++) begin
         if (first[k]) begin
            idx = idx | IDX_W'(k);
         end
      end
      if (!seen[SEL_BITS]) begin
         idx = IDX_W'(SEL_BITS);
      end
   end

endmodule

// File: rtl/cfgx_lane_mask.sv
module cfgx_lane_mask #(
   parameter int DW     = 32,
   localparam int NLANE = DW / 8,
   localparam int SZW   = cfgx_pkg::size_width(DW / 8),
   localparam int NPOW  = $clog2(DW / 8) + 1
) (
   input  logic [SZW-1:0] size,
   output logic [DW-1:0]  mask,
   output logic           size_ok
);

   logic [NPOW-1:0] pow_hit;

   generate
      if ((DW % 8) != 0 || DW < 8) begin : g_bad_dw
         $error("cfgx_lane_mask: data width must be a whole number of bytes");
      end
      if ((NLANE & (NLANE - 1)) != 0) begin : g_bad_lanes
         $error("cfgx_lane_mask: lane count must be a power of two");
      end
   endgenerate

   // One byte lane is kept when its index lies below the byte count.
   generate
      for (genvar b = 0; b < NLANE; b++) begin : g_lane
         localparam logic [SZW-1:0] LANE = SZW'(b);
         assign mask[b*8 +: 8] = {8{LANE < size}};
      end
   endgenerate

   // Legal sizes are the powers of two up to the full width.
   generate
      for (genvar p = 0; p < NPOW; p++) begin : g_pow
         localparam logic [SZW-1:0] POW = SZW'(1 << p);
         assign pow_hit[p] = (size == POW);
      end
   endgenerate

   assign size_ok = |pow_hit;

endmodule

// File: rtl/cfgx_ctrl.sv
module cfgx_ctrl
   import cfgx_pkg::*;
#(
   parameter int DW     = 32,
   parameter int CFG_AW = 15,
   localparam int SZW   = cfgx_pkg::size_width(DW / 8)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              take,
   input  logic              in_wr,
   input  logic [CFG_AW-1:0] in_addr,
   input  logic [SZW-1:0]    in_size,
   input  logic [DW-1:0]     in_wdata,
   input  logic [DW-1:0]     in_mask,
   output logic              ready,
   output logic              resp_valid,
   output logic [DW-1:0]     resp_rdata,
   output logic              cfg_req_valid,
   output logic              cfg_wr,
   output logic [CFG_AW-1:0] cfg_addr,
   output logic [SZW-1:0]    cfg_size,
   output logic [DW-1:0]     cfg_wdata,
   input  logic              cfg_rvalid,
   input  logic [DW-1:0]     cfg_rdata
);

   cfgx_state_e   state_q;
   logic [DW-1:0] rmask_q;
   logic          accept;

   assign ready  = (state_q == ST_IDLE);
   assign accept = ready & take;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q       <= ST_IDLE;
         rmask_q       <= '0;
         cfg_req_valid <= 1'b0;
         cfg_wr        <= 1'b0;
         cfg_addr      <= '0;
         cfg_size      <= '0;
         cfg_wdata     <= '0;
         resp_valid    <= 1'b0;
         resp_rdata    <= '0;
      end else begin
         cfg_req_valid <= accept;
         resp_valid    <= 1'b0;
         if (accept) begin
            cfg_wr    <= in_wr;
            cfg_addr  <= in_addr;
            cfg_size  <= in_size;
            cfg_wdata <= in_wdata & in_mask;
            if (in_wr) begin
               resp_valid <= 1'b1;
               resp_rdata <= '0;
            end else begin
               state_q <= ST_WAIT;
               rmask_q <= in_mask;
            end
         end else if (state_q == ST_WAIT && cfg_rvalid) begin
            resp_valid <= 1'b1;
            resp_rdata <= cfg_rdata & rmask_q;
            state_q    <= ST_IDLE;
         end
      end
   end

endmodule

// File: rtl/cfgx_xlate.sv
module cfgx_xlate #(
   parameter int            AW       = 32,
   parameter int            DW       = 32,
   parameter int            WIN_BITS = 22,
   parameter logic [AW-1:0] WIN_BASE = 32'h8080_0000,
   parameter int            OFS_BITS = 11,
   parameter int            SEL_BITS = 11,
   localparam int           IDX_W    = $clog2(SEL_BITS + 1),
   localparam int           CFG_AW   = OFS_BITS + IDX_W,
   localparam int           SZW      = cfgx_pkg::size_width(DW / 8)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [AW-1:0]     req_addr,
   input  logic              req_wr,
   input  logic [SZW-1:0]    req_size,
   input  logic [DW-1:0]     req_wdata,
   output logic              resp_valid,
   output logic [DW-1:0]     resp_rdata,
   output logic              cfg_req_valid,
   output logic              cfg_wr,
   output logic [CFG_AW-1:0] cfg_addr,
   output logic [SZW-1:0]    cfg_size,
   output logic [DW-1:0]     cfg_wdata,
   input  logic              cfg_rvalid,
   input  logic [DW-1:0]     cfg_rdata
);

   generate
      if (OFS_BITS + SEL_BITS != WIN_BITS) begin : g_bad_split
         $error("cfgx_xlate: offset and select bits must fill the window");
      end
      if ((1 << IDX_W) <= SEL_BITS) begin : g_bad_idx
         $error("cfgx_xlate: index field too narrow for the no-select code");
      end
   endgenerate

   logic              win_hit;
   logic              size_ok;
   logic [DW-1:0]     lane_mask;
   logic [IDX_W-1:0]  dev_idx;
   logic [CFG_AW-1:0] xl_addr;
   logic              take;

   cfgx_win_decode #(
      .AW       (AW),
      .WIN_BITS (WIN_BITS),
      .WIN_BASE (WIN_BASE)
   ) u_win (
      .addr_hi (req_addr[AW-1:WIN_BITS]),
      .hit     (win_hit)
   );

   cfgx_sel_scan #(
      .SEL_BITS (SEL_BITS)
   ) u_scan (
      .sel (req_addr[OFS_BITS +: SEL_BITS]),
      .idx (dev_idx)
   );

   cfgx_lane_mask #(
      .DW (DW)
   ) u_mask (
      .size    (req_size),
      .mask    (lane_mask),
      .size_ok (size_ok)
   );

   assign xl_addr = {dev_idx, req_addr[OFS_BITS-1:0]};
   assign take    = req_valid & win_hit & size_ok;

   cfgx_ctrl #(
      .DW     (DW),
      .CFG_AW (CFG_AW)
   ) u_ctrl (
      .clk           (clk),
      .rst           (rst),
      .take          (take),
      .in_wr         (req_wr),
      .in_addr       (xl_addr),
      .in_size       (req_size),
      .in_wdata      (req_wdata),
      .in_mask       (lane_mask),
      .ready         (req_ready),
      .resp_valid    (resp_valid),
      .resp_rdata    (resp_rdata),
      .cfg_req_valid (cfg_req_valid),
      .cfg_wr        (cfg_wr),
      .cfg_addr      (cfg_addr),
      .cfg_size      (cfg_size),
      .cfg_wdata     (cfg_wdata),
      .cfg_rvalid    (cfg_rvalid),
      .cfg_rdata     (cfg_rdata)
   );

endmodule

// File: rtl/cfgx_chk.sv
module cfgx_chk #(
   parameter int AW       = 32,
   parameter int DW       = 32,
   parameter int OFS_BITS = 11,
   parameter int SEL_BITS = 11,
   localparam int IDX_W   = $clog2(SEL_BITS + 1),
   localparam int CFG_AW  = OFS_BITS + IDX_W,
   localparam int SZW     = cfgx_pkg::size_width(DW / 8)
) (
   input logic              clk,
   input logic              rst,
   input logic              req_valid,
   input logic              req_ready,
   input logic [AW-1:0]     req_addr,
   input logic              req_wr,
   input logic [SZW-1:0]    req_size,
   input logic              resp_valid,
   input logic              cfg_req_valid,
   input logic              cfg_wr,
   input logic [CFG_AW-1:0] cfg_addr,
   input logic [SZW-1:0]    cfg_size,
   input logic [DW-1:0]     cfg_wdata,
   input logic              cfg_rvalid
);

   localparam logic [SZW-1:0] FULL = SZW'(DW / 8);

   a_r2_offset_kept: assert property (@(posedge clk) disable iff (rst)
      cfg_req_valid |-> cfg_addr[OFS_BITS-1:0] == $past(req_addr[OFS_BITS-1:0]));

   a_r4_idx_range: assert property (@(posedge clk) disable iff (rst)
      cfg_req_valid |-> cfg_addr[CFG_AW-1:OFS_BITS] <= IDX_W'(SEL_BITS));

   a_r5_size_fwd: assert property (@(posedge clk) disable iff (rst)
      cfg_req_valid |-> (cfg_size == $past(req_size)) && ($countones(cfg_size) == 1));

   a_r6_dir_fwd: assert property (@(posedge clk) disable iff (rst)
      cfg_req_valid |-> cfg_wr == $past(req_wr));

   a_r6_lanes_clear: assert property (@(posedge clk) disable iff (rst)
      (cfg_req_valid && cfg_wr && cfg_size != FULL) |-> (cfg_wdata >> {cfg_size, 3'b000}) == '0);

   a_r7_req_cause: assert property (@(posedge clk) disable iff (rst)
      cfg_req_valid |-> $past(req_valid) && $past(req_ready));

   a_r8_resp_cause: assert property (@(posedge clk) disable iff (rst)
      resp_valid |-> $past(cfg_rvalid) || ($past(req_wr) && $past(req_ready)));

   a_r9_busy_blocks: assert property (@(posedge clk) disable iff (rst)
      !req_ready |=> !cfg_req_valid);

endmodule

bind cfgx_xlate cfgx_chk #(
   .AW       (AW),
   .DW       (DW),
   .OFS_BITS (OFS_BITS),
   .SEL_BITS (SEL_BITS)
) u_chk (
   .clk           (clk),
   .rst           (rst),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .req_addr      (req_addr),
   .req_wr        (req_wr),
   .req_size      (req_size),
   .resp_valid    (resp_valid),
   .cfg_req_valid (cfg_req_valid),
   .cfg_wr        (cfg_wr),
   .cfg_addr      (cfg_addr),
   .cfg_size      (cfg_size),
   .cfg_wdata     (cfg_wdata),
   .cfg_rvalid    (cfg_rvalid)
);

// File: tb/sim_cfgx_xlate.sv
`timescale 1ns/1ps
module sim_cfgx_xlate;

   localparam logic [31:0] BASE = 32'h8080_0000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic        req_wr = 1'b0;
   logic [2:0]  req_size = 3'd4;
   logic [31:0] req_wdata = '0;
   logic        resp_valid;
   logic [31:0] resp_rdata;
   logic        cfg_req_valid;
   logic        cfg_wr;
   logic [14:0] cfg_addr;
   logic [2:0]  cfg_size;
   logic [31:0] cfg_wdata;
   logic        cfg_rvalid = 1'b0;
   logic [31:0] cfg_rdata = '0;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   cfgx_xlate u0 (
      .clk (clk), .rst (rst),
      .req_valid (req_valid), .req_ready (req_ready), .req_addr (req_addr),
      .req_wr (req_wr), .req_size (req_size), .req_wdata (req_wdata),
      .resp_valid (resp_valid), .resp_rdata (resp_rdata),
      .cfg_req_valid (cfg_req_valid), .cfg_wr (cfg_wr), .cfg_addr (cfg_addr),
      .cfg_size (cfg_size), .cfg_wdata (cfg_wdata),
      .cfg_rvalid (cfg_rvalid), .cfg_rdata (cfg_rdata)
   );

   // Expected configuration address: lowest set select bit, or 11.
   function automatic logic [14:0] exp_xl(input logic [31:0] a);
      int idx = 11;
      for (int k = 10; k >= 0; k--) begin
         if (a[11 + k]) idx = k;
      end
      return {4'(idx), a[10:0]};
   endfunction

   function automatic logic [31:0] exp_mask(input logic [2:0] s);
      case (s)
         3'd1:    return 32'h0000_00FF;
         3'd2:    return 32'h0000_FFFF;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Behavioural reference model, evaluated on each rising edge.
   bit          m_busy = 0;
   logic [31:0] m_mask = '0;
   bit          e_cfgv = 0, e_resp = 0, e_wr = 0;
   logic [14:0] e_addr = '0;
   logic [2:0]  e_size = '0;
   logic [31:0] e_wdata = '0, e_rdata = '0;
   bit          model_on = 0;

   always @(posedge clk) begin
      if (rst) begin
         m_busy = 0; e_cfgv = 0; e_resp = 0;
      end else begin
         e_cfgv = 0; e_resp = 0;
         if (!m_busy && req_valid && req_addr[31:22] == 10'h202 &&
             (req_size == 3'd1 || req_size == 3'd2 || req_size == 3'd4)) begin
            e_cfgv  = 1;
            e_addr  = exp_xl(req_addr);
            e_size  = req_size;
            e_wr    = req_wr;
            e_wdata = req_wdata & exp_mask(req_size);
            if (req_wr) begin
               e_resp = 1; e_rdata = '0;
            end else begin
               m_busy = 1; m_mask = exp_mask(req_size);
            end
         end else if (m_busy && cfg_rvalid) begin
            e_resp  = 1;
            e_rdata = cfg_rdata & m_mask;
            m_busy  = 0;
         end
      end
   end

   always @(negedge clk) begin
      if (!rst && model_on) begin
         chk("R8 model req_ready", 32'(req_ready), 32'(!m_busy));
         chk("R7 model cfg_req_valid", 32'(cfg_req_valid), 32'(e_cfgv));
         chk("R7 model resp_valid", 32'(resp_valid), 32'(e_resp));
         if (e_cfgv) begin
            chk("R3 model cfg_addr", 32'(cfg_addr), 32'(e_addr));
            chk("R5 model cfg_size", 32'(cfg_size), 32'(e_size));
            chk("R6 model cfg_wr", 32'(cfg_wr), 32'(e_wr));
            chk("R6 model cfg_wdata", cfg_wdata, e_wdata);
         end
         if (e_resp) chk("R8 model resp_rdata", resp_rdata, e_rdata);
      end
   end

   task automatic tick();
      @(posedge clk); #2;
   endtask

   task automatic do_read(input logic [31:0] a, input logic [2:0] s, input int lat,
                          input logic [31:0] d, input string tag);
      req_valid = 1; req_wr = 0; req_addr = a; req_size = s;
      tick();
      req_valid = 0;
      if (lat == 0) begin cfg_rvalid = 1; cfg_rdata = d; end
      #2;
      chk({tag, " cfg_req_valid"}, 32'(cfg_req_valid), 32'd1);
      chk({tag, " cfg_addr"}, 32'(cfg_addr), 32'(exp_xl(a)));
      chk("R8 ready low while waiting", 32'(req_ready), 32'd0);
      if (lat > 0) begin
         for (int j = 0; j < lat; j++) tick();
         cfg_rvalid = 1; cfg_rdata = d;
      end
      tick();
      cfg_rvalid = 0;
      #2;
      chk("R8 read resp_valid", 32'(resp_valid), 32'd1);
      chk("R8 read resp_rdata", resp_rdata, d & exp_mask(s));
      chk("R8 ready restored", 32'(req_ready), 32'd1);
      tick();
   endtask

   task automatic do_write(input logic [31:0] a, input logic [2:0] s, input logic [31:0] d);
      req_valid = 1; req_wr = 1; req_addr = a; req_size = s; req_wdata = d;
      tick();
      req_valid = 0;
      #2;
      chk("R7 write cfg_req_valid", 32'(cfg_req_valid), 32'd1);
      chk("R6 write cfg_wr", 32'(cfg_wr), 32'd1);
      chk("R6 write cfg_wdata", cfg_wdata, d & exp_mask(s));
      chk("R5 write cfg_size", 32'(cfg_size), 32'(s));
      chk("R7 write resp_valid", 32'(resp_valid), 32'd1);
      chk("R7 write resp_rdata", resp_rdata, 32'd0);
      tick();
      chk("R7 cfg_req_valid single cycle", 32'(cfg_req_valid), 32'd0);
   endtask

   task automatic do_ignored(input logic [31:0] a, input logic [2:0] s, input logic w,
                             input string tag);
      req_valid = 1; req_wr = w; req_addr = a; req_size = s; req_wdata = 32'hA5A5_A5A5;
      tick();
      req_valid = 0;
      #2;
      chk({tag, " no cfg_req_valid"}, 32'(cfg_req_valid), 32'd0);
      chk({tag, " no resp_valid"}, 32'(resp_valid), 32'd0);
      chk({tag, " ready kept"}, 32'(req_ready), 32'd1);
      tick();
   endtask

   initial begin
      #100000000;
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=hung expected=finish");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      rst = 0;
      #2;
      chk("R10 reset cfg_req_valid", 32'(cfg_req_valid), 32'd0);
      chk("R10 reset resp_valid", 32'(resp_valid), 32'd0);
      chk("R10 reset req_ready", 32'(req_ready), 32'd1);
      model_on = 1;
      tick();

      // Every select position, then none set (R3, R4), with varied latency.
      for (int p = 0; p < 12; p++) begin
         logic [31:0] a;
         a = BASE | 32'((p * 147 + 5) & 11'h7FF);
         if (p < 11) a = a | (32'd1 << (11 + p));
         do_read(a, 3'd4, p % 3, 32'h1234_0000 + 32'(p), (p < 11) ? "R3 onehot" : "R4 none set");
      end
      // Several select bits set: lowest wins (R3), offset kept (R2).
      do_read(BASE | (32'd1 << 14) | (32'd1 << 17) | (32'd1 << 21) | 32'h7FF,
              3'd4, 1, 32'hCAFE_F00D, "R3 lowest wins");
      do_read(BASE | 32'h3C0 | (32'd1 << 21), 3'd4, 0, 32'h0BAD_BEEF, "R2 offset");

      // Narrow reads mask upper lanes (R8).
      do_read(BASE | (32'd1 << 12) | 32'h004, 3'd1, 1, 32'hDEAD_BE77, "R3 byte read");
      do_read(BASE | (32'd1 << 13) | 32'h006, 3'd2, 2, 32'hDEAD_BE77, "R3 half read");

      // Writes of each size (R6, R7), then back to back.
      do_write(BASE | (32'd1 << 15) | 32'h010, 3'd1, 32'hDEAD_BEEF);
      do_write(BASE | (32'd1 << 16) | 32'h012, 3'd2, 32'hDEAD_BEEF);
      do_write(BASE | 32'h014, 3'd4, 32'hDEAD_BEEF);
      req_valid = 1; req_wr = 1; req_size = 3'd4;
      req_addr = BASE | (32'd1 << 11); req_wdata = 32'h1111_1111;
      tick();
      req_addr = BASE | (32'd1 << 20); req_wdata = 32'h2222_2222;
      tick();
      req_valid = 0;
      #2;
      chk("R7 back-to-back second write", cfg_wdata, 32'h2222_2222);
      tick();

      // Outside the window and illegal sizes are ignored (R1, R5).
      do_ignored(32'h8000_0000, 3'd4, 0, "R1 below window");
      do_ignored(32'h807F_FFFF, 3'd4, 1, "R1 just below");
      do_ignored(32'h80C0_0000, 3'd4, 0, "R1 just above");
      do_ignored(BASE | 32'h20, 3'd3, 1, "R5 size 3");
      do_ignored(BASE | 32'h20, 3'd0, 0, "R5 size 0");

      // Request held during a read wait is ignored (R9).
      req_valid = 1; req_wr = 0; req_size = 3'd4; req_addr = BASE | (32'd1 << 18);
      tick();
      req_wr = 1; req_addr = BASE | (32'd1 << 19); req_wdata = 32'h5555_5555;
      for (int j = 0; j < 3; j++) begin
         tick();
         #2;
         chk("R9 request while busy ignored", 32'(cfg_req_valid), 32'd0);
      end
      req_valid = 0;
      cfg_rvalid = 1; cfg_rdata = 32'h7777_0001;
      tick();
      cfg_rvalid = 0;
      #2;
      chk("R9 held read completes", resp_rdata, 32'h7777_0001);
      tick();

      // Stray read data while idle yields nothing (R9).
      cfg_rvalid = 1; cfg_rdata = 32'h9999_9999;
      tick();
      cfg_rvalid = 0;
      #2;
      chk("R9 stray rvalid ignored", 32'(resp_valid), 32'd0);
      tick();
      repeat (3) tick();

      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule